// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The block takes a wide set of level-sensitive interrupt lines, sorts them into fixed groups of eight neighbouring sources, and drives one output per group toward a downstream interrupt controller. Each source has an enable bit. A group output is high while at least one of its sources is both pending and enabled. Every input is sampled into a pending register on each clock, so a pending bit follows its line with one cycle of delay.

Software reaches the block over a simple synchronous register bus. Each 32-bit word covers four consecutive groups, one byte per group. The lowest group of the word sits in the lowest byte. For each set of four groups there are four words: one that turns enable bits on, one that turns them off, and two read-only views, raw and enabled. Two summary words follow the per-group words and hold one bit per group output. Any access the map does not allow raises a one-cycle error flag and changes no state.

A parameter limits how many groups respond to their inputs. This lets a smaller instance ignore the lines of the groups it does not use.

Top module: `irq_group_combiner`

## Requirements
- R1: Input line n belongs to group n/8 at bit n%8. In a status word, group 4q+k takes bits 8k+7..8k, where q is the quad and k the lane.
- R2: The word address selects quad q = addr[5:2] for word addresses 0..63. addr[1:0] selects the register: 0 enable-set, 1 enable-clear, 2 raw pending, 3 enabled pending.
- R3: A write to enable-set ORs the written bits into the enable bits of the quad's four groups.
- R4: A write to enable-clear clears every enable bit whose written bit is 1 and leaves the other enable bits unchanged.
- R5: A read of enable-set or enable-clear returns the current enable bits of the quad.
- R6: A read of the enabled-pending register returns raw pending AND enable for each group of the quad.
- R7: A group output is high exactly when its pending AND enable is nonzero. A change of an enable bit reaches the output in the cycle after the write.
- R8: Word 64 returns one bit per group for groups 0..31, and word 65 does the same for groups 32..63. Each bit is set when that group's pending AND enable is nonzero.
- R9: Inputs are level sensitive. A pending bit copies its input at every clock edge, so a change on an input line shows on the group output one clock later.
- R10: A write to a status register (2 or 3), to a summary word, or to a word address of 66 or more raises the error output for one cycle and changes no state.
- R11: A read at a word address of 66 or more returns zero and raises the error output for one cycle.
- R12: Reset clears all enable bits, all pending bits, the read data and the error output.
- R13: With ACTIVE_GROUPS below the group count, groups at or above that limit ignore their inputs: their pending bits stay zero and their outputs stay low.
- R14: Read data appears on the read-data output one clock after the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 512 | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 7 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle flag for an illegal access |
| grp_irq_o | output | 64 | One interrupt output per group |

## Verification
A fixed input pattern gives different bit patterns to groups in different quads and lanes: 0xA5 in group 0, 0x3C in group 5, 0x81 in group 33 and 0xFF in group 63. Because of this, a read that lands on the wrong byte lane, the wrong quad or the wrong summary word returns a value that cannot be mistaken for the right one. Partial enable masks with set and clear writes that overlap show whether the enable bits are ORed in, cleared, or overwritten. Writes to status and summary words and accesses beyond the map show whether an illegal access leaves the state alone. A second instance with a reduced group limit, driven by the same stimulus, shows that groups above the limit ignore their inputs while groups below it still respond.

// File: rtl/igc_pkg.sv
package igc_pkg;

    // Register slot inside one quad of four groups
    typedef enum logic [1:0] {
        SLOT_EN_SET  = 2'd0,
        SLOT_EN_CLR  = 2'd1,
        SLOT_RAW     = 2'd2,
        SLOT_MASKED  = 2'd3
    } quad_slot_e;

endpackage

// File: rtl/igc_addr_decode.sv
module igc_addr_decode
    import igc_pkg::*;
#(
    parameter int NUM_QUADS = 16,
    parameter int SUM_WORDS = 2,
    parameter int ADDR_W    = 7,
    localparam int QUAD_W   = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1,
    localparam int SUM_W    = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [QUAD_W-1:0] quad_o,
    output quad_slot_e        slot_o,
    output logic [SUM_W-1:0]  sum_idx_o,
    output logic              in_quads_o,
    output logic              in_sum_o,
    output logic              wr_set_o,
    output logic              wr_clr_o,
    output logic              illegal_o
);

    localparam int QUAD_WORDS = NUM_QUADS * 4;
    localparam int MAP_WORDS  = QUAD_WORDS + SUM_WORDS;

    logic [ADDR_W-1:0] sum_off;
    logic              wr_ok;

    always_comb begin
        in_quads_o = (int'(addr_i) < QUAD_WORDS);
        in_sum_o   = (int'(addr_i) >= QUAD_WORDS) && (int'(addr_i) < MAP_WORDS);
        quad_o     = addr_i[2 +: QUAD_W];
        slot_o     = quad_slot_e'(addr_i[1:0]);
        sum_off    = addr_i - ADDR_W'(QUAD_WORDS);
        sum_idx_o  = sum_off[SUM_W-1:0];

        wr_set_o   = wr_en_i && in_quads_o && (slot_o == SLOT_EN_SET);
        wr_clr_o   = wr_en_i && in_quads_o && (slot_o == SLOT_EN_CLR);
        wr_ok      = wr_set_o || wr_clr_o;

        illegal_o  = (wr_en_i && !wr_ok) ||
                     (rd_en_i && !(in_quads_o || in_sum_o));
    end

endmodule

// File: rtl/igc_group.sv
module igc_group #(
    parameter int GRP_W = 8,
    parameter bit LIVE  = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [GRP_W-1:0] src_i,
    input  logic             set_en_i,
    input  logic             clr_en_i,
    input  logic [GRP_W-1:0] bits_i,
    output logic [GRP_W-1:0] pend_o,
    output logic [GRP_W-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [GRP_W-1:0] pend;
        logic [GRP_W-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Level sampling; groups past the limit never record a source
        st_d.pend = LIVE ? src_i : '0;
        if (set_en_i) begin
            st_d.mask = st_q.mask | bits_i;
        end else if (clr_en_i) begin
            st_d.mask = st_q.mask & ~bits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & st_q.mask);

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import igc_pkg::*;
#(
    parameter int NUM_GROUPS    = 64,
    parameter int GRP_W         = 8,
    parameter int DATA_W        = 32,
    parameter int ACTIVE_GROUPS = NUM_GROUPS,
    localparam int GPW          = DATA_W / GRP_W,
    localparam int NUM_QUADS    = NUM_GROUPS / GPW,
    localparam int SUM_WORDS    = NUM_GROUPS / DATA_W,
    localparam int MAP_WORDS    = NUM_QUADS * 4 + SUM_WORDS,
    localparam int ADDR_W       = $clog2(MAP_WORDS),
    localparam int NUM_SRC      = NUM_GROUPS * GRP_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_SRC-1:0]    irq_i,
    input  logic                  wr_en_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  err_o,
    output logic [NUM_GROUPS-1:0] grp_irq_o
);

    localparam int QUAD_W = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1;
    localparam int SUM_W  = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_state_t;

    bus_state_t bus_d, bus_q;

    logic [QUAD_W-1:0] dec_quad;
    quad_slot_e        dec_slot;
    logic [SUM_W-1:0]  dec_sum_idx;
    logic              dec_in_quads;
    logic              dec_in_sum;
    logic              dec_wr_set;
    logic              dec_wr_clr;
    logic              dec_illegal;

    logic [GRP_W-1:0]   pend_arr [NUM_GROUPS];
    logic [GRP_W-1:0]   mask_arr [NUM_GROUPS];
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] pend_all;
    logic [DATA_W-1:0]  rd_word;

    igc_addr_decode #(
        .NUM_QUADS (NUM_QUADS),
        .SUM_WORDS (SUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .quad_o     (dec_quad),
        .slot_o     (dec_slot),
        .sum_idx_o  (dec_sum_idx),
        .in_quads_o (dec_in_quads),
        .in_sum_o   (dec_in_sum),
        .wr_set_o   (dec_wr_set),
        .wr_clr_o   (dec_wr_clr),
        .illegal_o  (dec_illegal)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int QIDX = g / GPW;
        localparam int LANE = g % GPW;
        logic hit;
        assign hit = (dec_quad == QUAD_W'(QIDX));

        igc_group #(
            .GRP_W (GRP_W),
            .LIVE  (g < ACTIVE_GROUPS)
        ) u_grp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .src_i    (irq_i[g*GRP_W +: GRP_W]),
            .set_en_i (dec_wr_set && hit),
            .clr_en_i (dec_wr_clr && hit),
            .bits_i   (wdata_i[LANE*GRP_W +: GRP_W]),
            .pend_o   (pend_arr[g]),
            .mask_o   (mask_arr[g]),
            .irq_o    (grp_irq_o[g])
        );

        assign mask_all[g*GRP_W +: GRP_W] = mask_arr[g];
        assign pend_all[g*GRP_W +: GRP_W] = pend_arr[g];
    end

    // Read multiplexer: one byte lane per group of the addressed quad
    always_comb begin
        rd_word = '0;
        if (dec_in_quads) begin
            for (int l = 0; l < GPW; l++) begin
                int gi;
                gi = int'(dec_quad) * GPW + l;
                if (gi < NUM_GROUPS) begin
                    case (dec_slot)
                        SLOT_EN_SET, SLOT_EN_CLR:
                            rd_word[l*GRP_W +: GRP_W] = mask_arr[gi];
                        SLOT_RAW:
                            rd_word[l*GRP_W +: GRP_W] = pend_arr[gi];
                        default:
                            rd_word[l*GRP_W +: GRP_W] = pend_arr[gi] & mask_arr[gi];
                    endcase
                end
            end
        end else if (dec_in_sum) begin
            rd_word = grp_irq_o[int'(dec_sum_idx)*DATA_W +: DATA_W];
        end
    end

    always_comb begin
        bus_d     = bus_q;
        bus_d.err = dec_illegal;
        if (rd_en_i) begin
            bus_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rdata_o = bus_q.rdata;
    assign err_o   = bus_q.err;

endmodule

// File: rtl/igc_checker.sv
module igc_checker #(
    parameter int NUM_GROUPS    = 64,
    parameter int GRP_W         = 8,
    parameter int DATA_W        = 32,
    parameter int ACTIVE_GROUPS = 64,
    parameter int ADDR_W        = 7,
    parameter int MAP_WORDS     = 66
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        wr_en_i,
    input logic                        rd_en_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [DATA_W-1:0]           wdata_i,
    input logic [DATA_W-1:0]           rdata_o,
    input logic                        err_o,
    input logic [NUM_GROUPS-1:0]       grp_irq_o,
    input logic [NUM_GROUPS*GRP_W-1:0] mask_all
);

    localparam int QUAD_WORDS = MAP_WORDS - NUM_GROUPS / DATA_W;

    logic status_wr;
    logic far_rd;
    assign status_wr = wr_en_i && (int'(addr_i) < QUAD_WORDS) && addr_i[1];
    assign far_rd    = rd_en_i && (int'(addr_i) >= MAP_WORDS);

    // R10
    err_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(wr_en_i || rd_en_i));

    // R10
    status_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_wr |=> $stable(mask_all) && err_o);

    // R11
    far_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        far_rd |=> (rdata_o == '0) && err_o);

    // R4
    clear_quad0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(1)) |=> (mask_all[DATA_W-1:0] & $past(wdata_i)) == '0);

    // R12
    reset_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (mask_all == '0) && (grp_irq_o == '0));

    if (ACTIVE_GROUPS < NUM_GROUPS) begin : g_lim
        // R13
        upper_groups_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            grp_irq_o[NUM_GROUPS-1:ACTIVE_GROUPS] == '0);
    end

endmodule

bind irq_group_combiner igc_checker #(
    .NUM_GROUPS    (NUM_GROUPS),
    .GRP_W         (GRP_W),
    .DATA_W        (DATA_W),
    .ACTIVE_GROUPS (ACTIVE_GROUPS),
    .ADDR_W        (ADDR_W),
    .MAP_WORDS     (MAP_WORDS)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .err_o     (err_o),
    .grp_irq_o (grp_irq_o),
    .mask_all  (mask_all)
);

// File: tb/sim_irq_group_combiner.sv
`timescale 1ns/1ps
module sim_irq_group_combiner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] irq = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [6:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata, lim_rdata;
    logic         err, lim_err;
    logic [63:0]  grp_irq, lim_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_group_combiner u0 (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .grp_irq_o(grp_irq)
    );

    irq_group_combiner #(.ACTIVE_GROUPS(40)) u_lim (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(lim_rdata), .err_o(lim_err), .grp_irq_o(lim_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    // Source pattern: group0=A5, group5=3C, group33=81, group63=FF
    localparam vec_t VEC [NV] = '{
        '{1'b0, 7'd2,  32'h0,        32'h000000A5, 1'b0, 8'd1},  // R1 raw lane 0, R14
        '{1'b0, 7'd3,  32'h0,        32'h00000000, 1'b0, 8'd6},  // R6 nothing enabled
        '{1'b1, 7'd0,  32'h0000000F, 32'h0,        1'b0, 8'd3},  // R3
        '{1'b0, 7'd0,  32'h0,        32'h0000000F, 1'b0, 8'd5},  // R5
        '{1'b0, 7'd3,  32'h0,        32'h00000005, 1'b0, 8'd6},  // R6
        '{1'b0, 7'd64, 32'h0,        32'h00000001, 1'b0, 8'd8},  // R8
        '{1'b1, 7'd1,  32'h00000001, 32'h0,        1'b0, 8'd4},  // R4
        '{1'b0, 7'd0,  32'h0,        32'h0000000E, 1'b0, 8'd4},  // R4
        '{1'b0, 7'd3,  32'h0,        32'h00000004, 1'b0, 8'd6},  // R6
        '{1'b1, 7'd4,  32'h0000FF00, 32'h0,        1'b0, 8'd2},  // R2 quad 1 lane 1
        '{1'b0, 7'd7,  32'h0,        32'h00003C00, 1'b0, 8'd2},  // R2
        '{1'b0, 7'd6,  32'h0,        32'h00003C00, 1'b0, 8'd1},  // R1
        '{1'b0, 7'd4,  32'h0,        32'h0000FF00, 1'b0, 8'd5},  // R5
        '{1'b1, 7'd32, 32'h0000FF00, 32'h0,        1'b0, 8'd3},  // R3 group 33
        '{1'b0, 7'd65, 32'h0,        32'h00000002, 1'b0, 8'd8},  // R8
        '{1'b0, 7'd64, 32'h0,        32'h00000021, 1'b0, 8'd8},  // R8
        '{1'b1, 7'd2,  32'hFFFFFFFF, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 7'd0,  32'h0,        32'h0000000E, 1'b0, 8'd10}, // R10 unchanged
        '{1'b1, 7'd3,  32'hFFFFFFFF, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b1, 7'd64, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b1, 7'd99, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 7'd70, 32'h0,        32'h00000000, 1'b1, 8'd11}, // R11
        '{1'b0, 7'd127,32'h0,        32'h00000000, 1'b1, 8'd11}, // R11
        '{1'b1, 7'd60, 32'hFF000000, 32'h0,        1'b0, 8'd3},  // R3 group 63
        '{1'b0, 7'd65, 32'h0,        32'h80000002, 1'b0, 8'd8},  // R8
        '{1'b1, 7'd61, 32'h80000000, 32'h0,        1'b0, 8'd4},  // R4
        '{1'b0, 7'd61, 32'h0,        32'h7F000000, 1'b0, 8'd5},  // R5
        '{1'b0, 7'd63, 32'h0,        32'h7F000000, 1'b0, 8'd6}   // R6
    };

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input vec_t v);
        @(negedge clk);
        wr_en = v.wr;
        rd_en = !v.wr;
        addr  = v.addr;
        wdata = v.data;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check(int'(v.req), 64'(err), 64'(v.err), "error flag");
        if (!v.wr) check(int'(v.req), 64'(rdata), 64'(v.exp), "read data");
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(12, 64'(grp_irq), 64'h0, "outputs in reset");
        check(12, 64'(rdata), 64'h0, "rdata in reset");
        check(12, 64'(err), 64'h0, "err in reset");
        rst_n = 1'b1;

        @(negedge clk);
        irq[7:0]     = 8'hA5;
        irq[47:40]   = 8'h3C;
        irq[271:264] = 8'h81;
        irq[511:504] = 8'hFF;
        repeat (2) @(negedge clk);
        check(7, 64'(grp_irq), 64'h0, "no output while nothing enabled"); // R7

        for (int i = 0; i < NV; i++) bus_op(VEC[i]);

        // R7 outputs follow enabled pending
        check(7, 64'(grp_irq), 64'h8000_0002_0000_0021, "group outputs");

        // R13 limited instance: group 63 ignored, group 33 alive
        check(13, 64'(lim_irq), 64'h0000_0002_0000_0021, "limited outputs");

        // R9 level following with one register of delay
        @(negedge clk);
        irq[7:0] = 8'h00;
        #1 check(9, 64'(grp_irq[0]), 64'h1, "before edge");
        @(negedge clk);
        check(9, 64'(grp_irq[0]), 64'h0, "after edge");
        irq[7:0] = 8'h04;
        @(negedge clk);
        check(9, 64'(grp_irq[0]), 64'h1, "re-raised");

        // R7 enable change reaches output next cycle
        bus_op('{1'b1, 7'd1, 32'h0000000E, 32'h0, 1'b0, 8'd7});
        check(7, 64'(grp_irq[0]), 64'h0, "disabled group drops");

        // R12 reset mid-run clears enables
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_op('{1'b0, 7'd4, 32'h0, 32'h00000000, 1'b0, 8'd12});
        check(12, 64'(grp_irq), 64'h0, "outputs after reset");

        done = 1'b1;
        report();
    end

endmodule